// File: doc/BRIEF.md
# Frame Jitter Buffer Controller

This block keeps track of how far the write side of a disc-playback de-jitter buffer has drifted from its centre. Demodulated frames are written at the disc's rate, and the buffer is read out on a crystal-derived frame clock. Each completed written frame moves the drift position one step up. Each completed read frame moves it one step down. From the current position the block picks a divide ratio for the bit-clock side of the spindle servo. When writes lag, the ratio is 589. When the buffer is centred, it is 588. When writes lead, it is 587. The servo uses this ratio to pull the buffer back toward its centre.

If the drift reaches the edge of the ±4-frame window in either direction, the write frame pointer is snapped back to the centre position. The data around that jump cannot be error-flagged, so the block raises a mute request for 128 read frames. The block also forms the byte write and read addresses for an 8-bit by 2048-word buffer from its two frame pointers and the byte offsets supplied by the writer and the reader.

The control core is a three-state zone machine. The states are ST_CENTRED (position 0), ST_BEHIND (position −3..−1) and ST_AHEAD (position +1..+3). Its transitions are as follows. The "lag" transition goes from ST_CENTRED to ST_BEHIND. The "lead" transition goes from ST_CENTRED to ST_AHEAD. The "settle" transition goes from ST_BEHIND or ST_AHEAD back to ST_CENTRED when the position returns to 0. A "recentre" transition goes from any state to ST_CENTRED when the position would reach ±4. The "cross" transition goes directly between ST_BEHIND and ST_AHEAD and cannot occur, because one frame event moves the position by at most one step. Every other frame event is a "hold" in the current state.

Top module: `frame_jitter_ctrl`

## Requirements
- R1: While rst_n is low, mute_req is 1. After reset, the outputs are as follows: drift 0, div_ratio 588, mute_req 0, write frame pointer 32 and read frame pointer 0.
- R2: On a clock edge with wr_frame_done=1 and rd_frame_done=0, drift rises by 1. With rd_frame_done=1 and wr_frame_done=0, drift falls by 1. With both or neither set, drift is unchanged.
- R3: div_ratio is an unsigned 10-bit value. It is 589 when drift is −3..−1, 588 when drift is 0, and 587 when drift is +1..+3.
- R4: A frame event that would take drift to +4 or −4 instead sets drift to 0 and div_ratio to 588. On that edge the write frame pointer becomes the updated read frame pointer plus 32, modulo 64.
- R5: After a recentre, mute_req is 1 from the next cycle onward. It returns to 0 on the edge of the 128th later read frame event. The read event on the recentre edge itself is not counted.
- R6: A recentre that occurs while mute_req is already active restarts the 128-read-frame count from full.
- R7: wr_addr = (write frame pointer × 32 + wr_ofs) mod 2048, and rd_addr = (read frame pointer × 32 + rd_ofs) mod 2048. Both are combinational in the offsets. Each frame pointer advances by 1 modulo 64 on its own frame event.
- R8: drift and div_ratio change only on an edge that carries a frame event. With no frame event they hold, even while the byte offsets change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_frame_done | input | 1 | One-cycle pulse: a frame has been written |
| rd_frame_done | input | 1 | One-cycle pulse: a frame has been read |
| wr_ofs | input | 5 | Byte offset within the frame being written |
| rd_ofs | input | 5 | Byte offset within the frame being read |
| wr_addr | output | 11 | Buffer write byte address |
| rd_addr | output | 11 | Buffer read byte address |
| div_ratio | output | 10 | Servo bit-clock divide ratio |
| mute_req | output | 1 | Mute request |
| drift | output | 4 | Signed drift position in frames |

## Verification
A wrong drift value or zone state shows up on drift and div_ratio on the clock edge right after the frame event that caused it. A wrong mute timer shows on mute_req either one cycle after a recentre or at the 128th read event after it. A slipped frame pointer appears immediately on wr_addr or rd_addr. Because the bench compares every output on every cycle, each such fault is visible within one cycle of the edge where the bad state is loaded. The only exception is a mute-count error, which surfaces at the read event where the count should have expired.

// File: rtl/fjb_pkg.sv
package fjb_pkg;

    typedef enum logic [1:0] {
        ST_CENTRED = 2'd0,
        ST_BEHIND  = 2'd1,
        ST_AHEAD   = 2'd2
    } zone_e;

    localparam int RATIO_W    = 10;
    localparam int RATIO_SLOW = 589;
    localparam int RATIO_MID  = 588;
    localparam int RATIO_FAST = 587;

endpackage

// File: rtl/fjb_pos_fsm.sv
module fjb_pos_fsm
    import fjb_pkg::*;
#(
    parameter int LIMIT = 4,
    localparam int PW = $clog2(LIMIT) + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_evt,
    input  logic                   rd_evt,
    output logic signed [PW-1:0]   pos,
    output logic                   recentre,
    output logic [RATIO_W-1:0]     div_ratio
);

    localparam logic signed [PW-1:0] POS_HI = PW'(LIMIT);
    localparam logic signed [PW-1:0] POS_LO = -POS_HI;

    zone_e                 state_q, state_d;
    logic signed [PW-1:0]  pos_q, pos_d, step, pos_sum;
    logic                  frame_evt;

    always_comb begin
        frame_evt = wr_evt | rd_evt;
        if (wr_evt && !rd_evt)      step = PW'(1);
        else if (rd_evt && !wr_evt) step = -PW'(1);
        else                        step = '0;
        pos_sum  = pos_q + step;
        recentre = frame_evt && ((pos_sum >= POS_HI) || (pos_sum <= POS_LO));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (frame_evt) begin
            pos_d = recentre ? '0 : pos_sum;
            unique case (state_q)
                ST_CENTRED: begin
                    if (pos_sum > 0)      state_d = ST_AHEAD;   // lead
                    else if (pos_sum < 0) state_d = ST_BEHIND;  // lag
                end
                ST_BEHIND: begin
                    if (recentre)          state_d = ST_CENTRED; // recentre
                    else if (pos_sum == 0) state_d = ST_CENTRED; // settle
                end
                ST_AHEAD: begin
                    if (recentre)          state_d = ST_CENTRED; // recentre
                    else if (pos_sum == 0) state_d = ST_CENTRED; // settle
                end
                default: state_d = ST_CENTRED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CENTRED;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // outputs
    always_comb begin
        pos = pos_q;
        unique case (state_q)
            ST_BEHIND:  div_ratio = RATIO_W'(RATIO_SLOW);
            ST_AHEAD:   div_ratio = RATIO_W'(RATIO_FAST);
            default:    div_ratio = RATIO_W'(RATIO_MID);
        endcase
    end

    AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q < POS_HI) && (pos_q > POS_LO)); // R4

    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !rd_evt && !recentre) |=> (pos_q == $past(pos_q) + PW'(1))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_evt && !rd_evt) |=> ($stable(div_ratio) && $stable(pos_q))); // R8

    AST_CENTRE_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 0) |-> (div_ratio == RATIO_W'(RATIO_MID))); // R3

    AST_RECENTRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        recentre |=> (pos_q == 0)); // R4

endmodule

// File: rtl/fjb_mute_timer.sv
module fjb_mute_timer #(
    parameter int MUTE_FRAMES = 128,
    localparam int CW = $clog2(MUTE_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic recentre,
    input  logic rd_evt,
    output logic mute_req
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (recentre)               cnt_q <= CW'(MUTE_FRAMES);
        else if (rd_evt && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign mute_req = !rst_n || (cnt_q != '0);

    AST_MUTE_AFTER_RECENTRE: assert property (@(posedge clk) disable iff (!rst_n)
        recentre |=> mute_req); // R5

    AST_MUTE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (recentre && mute_req) |=> (cnt_q == CW'(MUTE_FRAMES))); // R6

endmodule

// File: rtl/fjb_addr_gen.sv
module fjb_addr_gen #(
    parameter int DEPTH       = 2048,
    parameter int FRAME_BYTES = 32,
    localparam int AW      = $clog2(DEPTH),
    localparam int OW      = $clog2(FRAME_BYTES),
    localparam int NFRAMES = DEPTH / FRAME_BYTES,
    localparam int FPW     = $clog2(NFRAMES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_evt,
    input  logic           rd_evt,
    input  logic           recentre,
    input  logic [OW-1:0]  wr_ofs,
    input  logic [OW-1:0]  rd_ofs,
    output logic [FPW-1:0] wr_ptr,
    output logic [FPW-1:0] rd_ptr,
    output logic [AW-1:0]  wr_addr,
    output logic [AW-1:0]  rd_addr
);

    localparam logic [FPW-1:0] CENTRE = FPW'(NFRAMES / 2);

    logic [FPW-1:0] rd_nx, wr_nx;

    always_comb begin
        rd_nx = rd_ptr + FPW'(rd_evt);
        wr_nx = recentre ? (rd_nx + CENTRE) : (wr_ptr + FPW'(wr_evt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= CENTRE;
            rd_ptr <= '0;
        end else begin
            wr_ptr <= wr_nx;
            rd_ptr <= rd_nx;
        end
    end

    assign wr_addr = AW'(AW'(wr_ptr) * AW'(FRAME_BYTES) + AW'(wr_ofs));
    assign rd_addr = AW'(AW'(rd_ptr) * AW'(FRAME_BYTES) + AW'(rd_ofs));

    AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> (rd_ptr == $past(rd_ptr) + FPW'(1))); // R7

endmodule

// File: rtl/frame_jitter_ctrl.sv
module frame_jitter_ctrl
    import fjb_pkg::*;
#(
    parameter int DEPTH       = 2048,
    parameter int FRAME_BYTES = 32,
    parameter int LIMIT       = 4,
    parameter int MUTE_FRAMES = 128,
    localparam int AW  = $clog2(DEPTH),
    localparam int OW  = $clog2(FRAME_BYTES),
    localparam int PW  = $clog2(LIMIT) + 2,
    localparam int FPW = $clog2(DEPTH / FRAME_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_frame_done,
    input  logic                 rd_frame_done,
    input  logic [OW-1:0]        wr_ofs,
    input  logic [OW-1:0]        rd_ofs,
    output logic [AW-1:0]        wr_addr,
    output logic [AW-1:0]        rd_addr,
    output logic [RATIO_W-1:0]   div_ratio,
    output logic                 mute_req,
    output logic signed [PW-1:0] drift
);

    localparam logic [FPW-1:0] CENTRE = FPW'((DEPTH / FRAME_BYTES) / 2);

    logic           recentre;
    logic [FPW-1:0] wr_ptr, rd_ptr;

    fjb_pos_fsm #(.LIMIT(LIMIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_frame_done),
        .rd_evt    (rd_frame_done),
        .pos       (drift),
        .recentre  (recentre),
        .div_ratio (div_ratio)
    );

    fjb_mute_timer #(.MUTE_FRAMES(MUTE_FRAMES)) u_mute (
        .clk      (clk),
        .rst_n    (rst_n),
        .recentre (recentre),
        .rd_evt   (rd_frame_done),
        .mute_req (mute_req)
    );

    fjb_addr_gen #(.DEPTH(DEPTH), .FRAME_BYTES(FRAME_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_evt   (wr_frame_done),
        .rd_evt   (rd_frame_done),
        .recentre (recentre),
        .wr_ofs   (wr_ofs),
        .rd_ofs   (rd_ofs),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr)
    );

    AST_PTR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (FPW'(wr_ptr - rd_ptr) == FPW'(CENTRE + FPW'(drift)))); // R4

endmodule

// File: tb/frame_jitter_ctrl_tb.sv
module frame_jitter_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [4:0]  wofs = '0, rofs = '0;
    logic [10:0] wr_addr, rd_addr;
    logic [9:0]  div_ratio;
    logic        mute_req;
    logic signed [3:0] drift;

    int vectors = 0, errors = 0, cycles = 0;
    int m_pos = 0, m_wp = 32, m_rp = 0, m_cnt = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    frame_jitter_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_frame_done(wr), .rd_frame_done(rd),
        .wr_ofs(wofs), .rd_ofs(rofs), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .div_ratio(div_ratio), .mute_req(mute_req), .drift(drift)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0; m_wp = 32; m_rp = 0; m_cnt = 0;
        end else begin
            int s;
            s = m_pos + (wr ? 1 : 0) - (rd ? 1 : 0);
            m_rp = (m_rp + (rd ? 1 : 0)) % 64;
            if ((wr || rd) && (s >= 4 || s <= -4)) begin
                m_pos = 0;
                m_wp  = (m_rp + 32) % 64;
                m_cnt = 128;
            end else begin
                m_pos = s;
                m_wp  = (m_wp + (wr ? 1 : 0)) % 64;
                if (rd && m_cnt > 0) m_cnt = m_cnt - 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog (phase %s) act=hung exp=done", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic compare();
        int e_div, e_wa, e_ra;
        bit e_mute;
        e_div  = (m_pos < 0) ? 589 : (m_pos > 0) ? 587 : 588;
        e_wa   = (m_wp * 32 + wofs) % 2048;
        e_ra   = (m_rp * 32 + rofs) % 2048;
        e_mute = !rst_n || (m_cnt != 0);
        vectors++;
        if (int'(drift) != m_pos) begin
            errors++; $display("FAIL R2 (phase %s) drift act=%0d exp=%0d", phase, drift, m_pos);
        end
        if (int'(div_ratio) != e_div) begin
            errors++; $display("FAIL R3 (phase %s) div_ratio act=%0d exp=%0d", phase, div_ratio, e_div);
        end
        if (mute_req != e_mute) begin
            errors++; $display("FAIL R5 (phase %s) mute_req act=%0b exp=%0b", phase, mute_req, e_mute);
        end
        if (int'(wr_addr) != e_wa) begin
            errors++; $display("FAIL R7 (phase %s) wr_addr act=%0d exp=%0d", phase, wr_addr, e_wa);
        end
        if (int'(rd_addr) != e_ra) begin
            errors++; $display("FAIL R7 (phase %s) rd_addr act=%0d exp=%0d", phase, rd_addr, e_ra);
        end
    endtask

    // hold w/r for n cycles, comparing after each edge
    task automatic run(input bit w, input bit r, input int n, input bit rnd_ofs);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            wr = w; rd = r;
            if (rnd_ofs) begin
                wofs = 5'($urandom); rofs = 5'($urandom);
            end
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        run(0, 0, 3, 1);
        // R2 / R3: walk through the positive and negative zones
        phase = "R2";
        run(1, 0, 3, 0);
        run(0, 0, 2, 1);
        run(0, 1, 6, 0);
        run(1, 1, 3, 1);
        run(1, 0, 3, 0);
        // R4: overflow at +4
        phase = "R4";
        run(1, 0, 4, 0);
        run(0, 0, 2, 0);
        // R6: partial mute, then underflow reloads the count
        phase = "R6";
        run(1, 1, 100, 1);
        run(0, 1, 4, 0);
        // R5: count 128 read events to mute release
        phase = "R5";
        run(1, 1, 127, 0);
        run(1, 1, 3, 0);
        // R8: idle with changing offsets
        phase = "R8";
        run(0, 0, 10, 1);
        // R7: long mixed traffic wraps pointers
        phase = "R7";
        for (int k = 0; k < 3000; k++) begin
            int sel;
            sel = int'($urandom % 5);
            run(sel == 0 || sel == 2, sel == 1 || sel == 2, 1, 1);
        end
        // R1: reset in mid-run
        phase = "R1";
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0; rd = 1'b0;
        run(0, 0, 2, 0);
        rst_n = 1'b1;
        run(0, 0, 2, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule